// File: doc/BRIEF.md
# Deferred Reply Tracker

This block follows, on the requesting side of a pipelined split-transaction bus, the requests whose answer the responder has put off. Each issued request first waits in an in-order queue for its response phase. When the response phase says the request was deferred, the block moves the request's 8-bit tag into an outstanding table. Later the responder starts a separate reply transaction that carries the tag in its address field. The block matches that tag against the table in any order. It records the snoop-phase hit level as the final state of the returned line. When a normal response completes the reply, it retires the entry.

The reply transaction holds its own place in the in-order queue, because its snoop and response phases follow bus order and not table order. On completion the block emits a one-cycle report with the tag and the final line state. It raises separate one-cycle flags for a defer that finds the table full and for a reply that cannot be accepted. The count of live table entries is always visible. Once the reply has been seen, the requester takes snoop responsibility for the line back. The data transfer and the snoop machinery themselves belong to other blocks.

Top module: `defer_reply_tracker`

## Requirements
- R1: After reset (`rst_n` low, active low), the table and the in-order queue are empty: `pending_cnt` is 0, `iss_ready` is 1, and `cmp_valid`, `err_ovf` and `err_unmatched` are 0.
- R2: A request offered with `iss_valid` while `iss_ready` is 1 enters the in-order queue in the next clock. `iss_ready` is 1 only while the queue holds at most IOQ_DEPTH-2 entries (default: 2), so that one slot always stays free for a reply. A request offered while `iss_ready` is 0 is dropped.
- R3: `dfr_valid` takes the oldest queued entry off the queue when that entry is an issued request, and stores its tag in the table in the next clock. With SLOTS (8) entries already live, the tag is not stored, `err_ovf` is 1 for one cycle, and `pending_cnt` stays the same. A defer with an empty queue, or with a reply at the head, has no effect.
- R4: A reply whose tag equals no live, not-yet-replied entry is refused. This includes a second reply for the same tag. A reply is also refused when the in-order queue is full. A refused reply sets `err_unmatched` for one cycle, two clocks after the bus cycle that carried it, and changes no entry.
- R5: Bus inputs are registered once, so a reply is acted on one clock after its bus cycle. Replies may arrive in any order relative to the defers. An accepted reply marks its entry and joins the in-order queue behind the entries already there.
- R6: A hit strobe (`bus_hit_valid`), sampled one clock after its bus cycle, records the `bus_hit` level for the reply at the head of the queue. A strobe in the same bus cycle as that reply's response also counts. The final state is shared (`cmp_shared`=1) if a strobe recorded hit=1, and exclusive (0) if the strobe recorded 0 or no strobe came.
- R7: A response with code 2'b00 (normal) takes the head entry off the queue. If the head is a reply, its table entry is freed, and two clocks after the response's bus cycle `cmp_valid` is 1 for one cycle, with `cmp_id` equal to the tag and `cmp_shared` set as in R6. A normal response with an issued request at the head produces no completion.
- R8: Response codes 2'b01, 2'b10 and 2'b11 leave the queue, the table and the completion output unchanged.
- R9: `pending_cnt` equals the number of live table entries: it rises after each stored defer and falls after each completion.
- R10: When a normal response and `dfr_valid` act in the same clock, the response wins and the defer notice is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | A request with tag `iss_id` is issued |
| iss_id | input | ID_W | Tag of the issued request |
| iss_ready | output | 1 | The in-order queue can take a request |
| dfr_valid | input | 1 | The oldest queued request was deferred |
| bus_rep_valid | input | 1 | A deferred reply is on the bus |
| bus_rep_id | input | ID_W | Tag carried in the reply's address field |
| bus_hit_valid | input | 1 | Snoop-phase strobe for the head reply |
| bus_hit | input | 1 | Hit level: 1 means the line is shared |
| bus_rsp_valid | input | 1 | Response phase for the head entry |
| bus_rsp_code | input | 2 | Response code, 2'b00 = normal completion |
| cmp_valid | output | 1 | One-cycle completion of a deferred request |
| cmp_id | output | ID_W | Tag of the completed request |
| cmp_shared | output | 1 | Final line state: 1 shared, 0 exclusive |
| err_ovf | output | 1 | A defer found the table full |
| err_unmatched | output | 1 | A reply was refused |
| pending_cnt | output | $clog2(SLOTS+1) | Live table entries |

## Verification
A corrupted table tag or a lost replied mark shows up at the ports within two clocks of the next reply for that tag: `err_unmatched` rises where it should stay low, or a stale entry is accepted a second time. A wrong queue order, or a slot number attached to the wrong queue entry, shows up at the next normal response: `cmp_id` or `cmp_shared` differs from the reply that should be at the head, or `pending_cnt` fails to fall. The bench therefore runs replies out of order and sends duplicate and unknown tags. It fills the table to overflow and lines a defer up against a response, and checks every one of these effects in the exact cycle it is due.

// File: rtl/drt_pkg.sv
package drt_pkg;

  typedef enum logic [1:0] {
    RSP_NORMAL = 2'b00,
    RSP_RETRY  = 2'b01,
    RSP_FAULT  = 2'b10,
    RSP_HARD   = 2'b11
  } rsp_code_e;

  // Only a normal code finishes the head transaction.
  function automatic logic rsp_completes(input logic [1:0] code);
    return code == RSP_NORMAL;
  endfunction

  // Line ends shared only when a snoop strobe reported a hit.
  function automatic logic final_state_shared(input logic strobe_seen, input logic hit_level);
    return strobe_seen & hit_level;
  endfunction

endpackage

// File: rtl/drt_bus_obs.sv
module drt_bus_obs #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rep_valid_i,
  input  logic [ID_W-1:0] rep_id_i,
  input  logic            hit_valid_i,
  input  logic            hit_i,
  input  logic            rsp_valid_i,
  input  logic [1:0]      rsp_code_i,
  output logic            rep_valid_o,
  output logic [ID_W-1:0] rep_id_o,
  output logic            hit_valid_o,
  output logic            hit_o,
  output logic            rsp_valid_o,
  output logic [1:0]      rsp_code_o
);

  // One observation stage: the requester acts a clock after the bus cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_valid_o <= 1'b0;
      rep_id_o    <= '0;
      hit_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= 2'b00;
    end else begin
      rep_valid_o <= rep_valid_i;
      rep_id_o    <= rep_id_i;
      hit_valid_o <= hit_valid_i;
      hit_o       <= hit_i;
      rsp_valid_o <= rsp_valid_i;
      rsp_code_o  <= rsp_code_i;
    end
  end

endmodule

// File: rtl/drt_ioq.sv
module drt_ioq #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_a,
  input  logic [W-1:0]               data_a,
  input  logic                       push_b,
  input  logic [W-1:0]               data_b,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q, wr_b;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // Port a (replies) is placed ahead of port b (issues) in the same clock.
  assign wr_b = push_a ? step(wr_q) : wr_q;

  always_ff @(posedge clk) begin
    if (push_a) mem[wr_q] <= data_a;
    if (push_b) mem[wr_b] <= data_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_a && push_b) wr_q <= step(step(wr_q));
      else if (push_a || push_b) wr_q <= step(wr_q);
      if (pop) rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(push_a) + CW'(push_b) - CW'(pop);
    end
  end

  assign head  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign cnt   = cnt_q;

  assert_ioq_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);

endmodule

// File: rtl/drt_table.sv
module drt_table #(
  parameter int ID_W  = 8,
  parameter int SLOTS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc,
  input  logic [ID_W-1:0]            alloc_id,
  input  logic [ID_W-1:0]            lookup_id,
  input  logic                       mark,
  input  logic                       hit_wr,
  input  logic                       hit_val,
  input  logic                       retire,
  input  logic [$clog2(SLOTS)-1:0]   rd_slot,
  output logic                       full,
  output logic                       match,
  output logic [$clog2(SLOTS)-1:0]   match_slot,
  output logic [ID_W-1:0]            rd_id,
  output logic                       rd_seen,
  output logic                       rd_hit,
  output logic [$clog2(SLOTS+1)-1:0] cnt
);

  localparam int SW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS+1);

  logic [SLOTS-1:0] valid_vec, replied_vec, seen_vec, hit_vec, cand_vec;
  logic [ID_W-1:0]  id_arr [SLOTS];
  logic [SW-1:0]    free_slot;
  logic             alloc_ok;
  logic [CW-1:0]    cnt_q;

  function automatic logic [SW-1:0] lowest_set(input logic [SLOTS-1:0] v);
    logic [SW-1:0] r;
    r = '0;
    for (int k = SLOTS-1; k >= 0; k--) if (v[k]) r = SW'(k);
    return r;
  endfunction

  assign full       = &valid_vec;
  assign alloc_ok   = alloc & ~full;
  assign free_slot  = lowest_set(~valid_vec);
  assign match      = |cand_vec;
  assign match_slot = lowest_set(cand_vec);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic            v_q, rep_q, seen_q, hit_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        rep_q  <= 1'b0;
        seen_q <= 1'b0;
        hit_q  <= 1'b0;
        id_q   <= '0;
      end else if (retire && rd_slot == SW'(i)) begin
        v_q    <= 1'b0;
        rep_q  <= 1'b0;
        seen_q <= 1'b0;
        hit_q  <= 1'b0;
      end else begin
        if (alloc_ok && free_slot == SW'(i)) begin
          v_q    <= 1'b1;
          rep_q  <= 1'b0;
          seen_q <= 1'b0;
          hit_q  <= 1'b0;
          id_q   <= alloc_id;
        end
        if (mark && match_slot == SW'(i)) rep_q <= 1'b1;
        if (hit_wr && rd_slot == SW'(i)) begin
          seen_q <= 1'b1;
          hit_q  <= hit_val;
        end
      end
    end

    assign valid_vec[i]   = v_q;
    assign replied_vec[i] = rep_q;
    assign seen_vec[i]    = seen_q;
    assign hit_vec[i]     = hit_q;
    assign id_arr[i]      = id_q;
    assign cand_vec[i]    = v_q & ~rep_q & (id_q == lookup_id);
  end

  assign rd_id   = id_arr[rd_slot];
  assign rd_seen = seen_vec[rd_slot];
  assign rd_hit  = hit_vec[rd_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CW'(alloc_ok) - CW'(retire);
  end
  assign cnt = cnt_q;

  assert_count_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'($countones(valid_vec)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && full) |=> cnt_q == $past(cnt_q) - CW'($past(retire)));

  assert_unmatched_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark && !alloc && !retire) |=> $stable(replied_vec) && $stable(valid_vec));

  assert_replied_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (replied_vec & ~valid_vec) == '0);

endmodule

// File: rtl/defer_reply_tracker.sv
module defer_reply_tracker
  import drt_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int SLOTS     = 8,
  parameter int IOQ_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       iss_valid,
  input  logic [ID_W-1:0]            iss_id,
  output logic                       iss_ready,
  input  logic                       dfr_valid,
  input  logic                       bus_rep_valid,
  input  logic [ID_W-1:0]            bus_rep_id,
  input  logic                       bus_hit_valid,
  input  logic                       bus_hit,
  input  logic                       bus_rsp_valid,
  input  logic [1:0]                 bus_rsp_code,
  output logic                       cmp_valid,
  output logic [ID_W-1:0]            cmp_id,
  output logic                       cmp_shared,
  output logic                       err_ovf,
  output logic                       err_unmatched,
  output logic [$clog2(SLOTS+1)-1:0] pending_cnt
);

  localparam int SW  = $clog2(SLOTS);
  localparam int QW  = ID_W + 1;
  localparam int QCW = $clog2(IOQ_DEPTH+1);

  // Observed bus, one clock late
  logic            obs_rep_valid, obs_hit_valid, obs_hit, obs_rsp_valid;
  logic [ID_W-1:0] obs_rep_id;
  logic [1:0]      obs_rsp_code;

  // Queue view: entry = {is_reply, payload}
  logic [QW-1:0]   head;
  logic            ioq_empty;
  logic [QCW-1:0]  ioq_cnt;
  logic            head_valid, head_is_rep;
  logic [ID_W-1:0] head_pl;

  // Table view
  logic            tbl_full, tbl_match, tbl_rd_seen, tbl_rd_hit;
  logic [SW-1:0]   tbl_match_slot, head_slot;
  logic [ID_W-1:0] tbl_rd_id;

  // Named events
  logic rsp_done, retire_evt, dfr_act, alloc_evt, ovf_evt;
  logic rep_push, unm_evt, iss_push, hit_wr, pop_evt, shared_now;

  drt_bus_obs #(.ID_W(ID_W)) u_obs (
    .clk(clk), .rst_n(rst_n),
    .rep_valid_i(bus_rep_valid), .rep_id_i(bus_rep_id),
    .hit_valid_i(bus_hit_valid), .hit_i(bus_hit),
    .rsp_valid_i(bus_rsp_valid), .rsp_code_i(bus_rsp_code),
    .rep_valid_o(obs_rep_valid), .rep_id_o(obs_rep_id),
    .hit_valid_o(obs_hit_valid), .hit_o(obs_hit),
    .rsp_valid_o(obs_rsp_valid), .rsp_code_o(obs_rsp_code)
  );

  assign head_valid  = ~ioq_empty;
  assign head_is_rep = head[QW-1];
  assign head_pl     = head[ID_W-1:0];
  assign head_slot   = SW'(head_pl);

  assign rsp_done   = obs_rsp_valid && rsp_completes(obs_rsp_code) && head_valid;
  assign retire_evt = rsp_done && head_is_rep;
  assign dfr_act    = dfr_valid && head_valid && !head_is_rep && !rsp_done;
  assign alloc_evt  = dfr_act && !tbl_full;
  assign ovf_evt    = dfr_act && tbl_full;
  assign pop_evt    = rsp_done || dfr_act;

  assign rep_push   = obs_rep_valid && tbl_match && (ioq_cnt < QCW'(IOQ_DEPTH));
  assign unm_evt    = obs_rep_valid && !rep_push;

  assign iss_ready  = (ioq_cnt <= QCW'(IOQ_DEPTH-2));
  assign iss_push   = iss_valid && iss_ready;

  assign hit_wr     = obs_hit_valid && head_valid && head_is_rep;
  assign shared_now = final_state_shared(obs_hit_valid | tbl_rd_seen,
                                         obs_hit_valid ? obs_hit : tbl_rd_hit);

  drt_ioq #(.W(QW), .DEPTH(IOQ_DEPTH)) u_ioq (
    .clk(clk), .rst_n(rst_n),
    .push_a(rep_push), .data_a({1'b1, ID_W'(tbl_match_slot)}),
    .push_b(iss_push), .data_b({1'b0, iss_id}),
    .pop(pop_evt),
    .head(head), .empty(ioq_empty), .cnt(ioq_cnt)
  );

  drt_table #(.ID_W(ID_W), .SLOTS(SLOTS)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .alloc(dfr_act), .alloc_id(head_pl),
    .lookup_id(obs_rep_id), .mark(rep_push),
    .hit_wr(hit_wr), .hit_val(obs_hit),
    .retire(retire_evt), .rd_slot(head_slot),
    .full(tbl_full), .match(tbl_match), .match_slot(tbl_match_slot),
    .rd_id(tbl_rd_id), .rd_seen(tbl_rd_seen), .rd_hit(tbl_rd_hit),
    .cnt(pending_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_valid     <= 1'b0;
      cmp_id        <= '0;
      cmp_shared    <= 1'b0;
      err_ovf       <= 1'b0;
      err_unmatched <= 1'b0;
    end else begin
      cmp_valid     <= retire_evt;
      err_ovf       <= ovf_evt;
      err_unmatched <= unm_evt;
      if (retire_evt) begin
        cmp_id     <= tbl_rd_id;
        cmp_shared <= shared_now;
      end
    end
  end

  // A defer notice that was acted on always empties one queue slot (R3, R10).
  assert_defer_pops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dfr_act && !rep_push && !iss_push) |=> ioq_cnt == $past(ioq_cnt) - 1'b1);

  // A stored defer raises the live count by one unless an entry retires (R9).
  assert_alloc_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_evt && !retire_evt) |=> pending_cnt == $past(pending_cnt) + 1'b1);

  // alloc_evt is consumed only by the assertion above.
  logic unused_alloc;
  assign unused_alloc = alloc_evt;

endmodule

// File: tb/defer_reply_tracker_test.sv
module defer_reply_tracker_test;

  localparam int CLK_P = 10;
  localparam int NVEC  = 5;
  // {tag[7:0], hit mode[1:0] (0 none, 1 own cycle, 2 with response), hit level, expected shared}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h00, 2'd1, 1'b1, 1'b1},
    {8'hFF, 2'd1, 1'b0, 1'b0},
    {8'h5A, 2'd0, 1'b1, 1'b0},
    {8'h81, 2'd2, 1'b1, 1'b1},
    {8'h3C, 2'd2, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0, dfr_valid = 1'b0;
  logic [7:0] iss_id = '0, bus_rep_id = '0;
  logic       bus_rep_valid = 1'b0, bus_hit_valid = 1'b0, bus_hit = 1'b0, bus_rsp_valid = 1'b0;
  logic [1:0] bus_rsp_code = 2'b00;
  logic       iss_ready, cmp_valid, cmp_shared, err_ovf, err_unmatched;
  logic [7:0] cmp_id;
  logic [3:0] pending_cnt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  defer_reply_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_ready(iss_ready),
    .dfr_valid(dfr_valid),
    .bus_rep_valid(bus_rep_valid), .bus_rep_id(bus_rep_id),
    .bus_hit_valid(bus_hit_valid), .bus_hit(bus_hit),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_code(bus_rsp_code),
    .cmp_valid(cmp_valid), .cmp_id(cmp_id), .cmp_shared(cmp_shared),
    .err_ovf(err_ovf), .err_unmatched(err_unmatched), .pending_cnt(pending_cnt)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic issue(input logic [7:0] id);
    iss_valid = 1'b1; iss_id = id; tick(); iss_valid = 1'b0;
  endtask

  task automatic defer();
    dfr_valid = 1'b1; tick(); dfr_valid = 1'b0;
  endtask

  // Reply on the bus for one cycle; result visible after the second edge.
  task automatic reply(input logic [7:0] id);
    bus_rep_valid = 1'b1; bus_rep_id = id; tick(); bus_rep_valid = 1'b0; tick();
  endtask

  task automatic hit(input logic h);
    bus_hit_valid = 1'b1; bus_hit = h; tick(); bus_hit_valid = 1'b0; tick();
  endtask

  task automatic respond(input logic [1:0] code, input logic with_hit, input logic h);
    bus_rsp_valid = 1'b1; bus_rsp_code = code;
    bus_hit_valid = with_hit; bus_hit = h;
    tick();
    bus_rsp_valid = 1'b0; bus_hit_valid = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pending_cnt", pending_cnt, 0);
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 cmp_valid", cmp_valid, 0);
    chk("R1 err_ovf", err_ovf, 0);
    chk("R1 err_unmatched", err_unmatched, 0);

    // Vector walk: full deferred flow per entry (R3 R5 R6 R7 R9)
    for (int v = 0; v < NVEC; v++) begin
      issue(VEC[v][11:4]);
      defer();
      chk("R3 stored after defer", pending_cnt, 1);
      reply(VEC[v][11:4]);
      chk("R5 reply accepted", err_unmatched, 0);
      if (VEC[v][3:2] == 2'd1) begin
        hit(VEC[v][1]);
        respond(2'b00, 1'b0, 1'b0);
      end else if (VEC[v][3:2] == 2'd2) begin
        respond(2'b00, 1'b1, VEC[v][1]);
      end else begin
        respond(2'b00, 1'b0, 1'b0);
      end
      chk("R7 cmp_valid", cmp_valid, 1);
      chk("R7 cmp_id", cmp_id, VEC[v][11:4]);
      chk("R6 cmp_shared", cmp_shared, VEC[v][0]);
      chk("R9 count after retire", pending_cnt, 0);
      tick();
      chk("R7 one-cycle completion", cmp_valid, 0);
    end

    // R4 unknown tag with empty table, then a normal response with empty queue
    reply(8'h77);
    chk("R4 unknown tag flagged", err_unmatched, 1);
    chk("R4 no state change", pending_cnt, 0);
    tick();
    chk("R4 flag lasts one cycle", err_unmatched, 0);
    respond(2'b00, 1'b0, 1'b0);
    chk("R7 no completion when queue empty", cmp_valid, 0);

    // R5 out-of-order replies, R4 duplicate reply
    issue(8'h11); issue(8'h22); issue(8'h33);
    defer(); defer(); defer();
    chk("R9 three live", pending_cnt, 3);
    reply(8'h33); reply(8'h11); reply(8'h22);
    chk("R5 out-of-order accepted", err_unmatched, 0);
    reply(8'h11);
    chk("R4 duplicate refused", err_unmatched, 1);
    respond(2'b00, 1'b1, 1'b1);
    chk("R5 first completion tag", cmp_id, 8'h33);
    chk("R6 first completion shared", cmp_shared, 1);
    respond(2'b00, 1'b0, 1'b0);
    chk("R5 second completion tag", cmp_id, 8'h11);
    chk("R6 second completion exclusive", cmp_shared, 0);
    respond(2'b00, 1'b0, 1'b0);
    chk("R5 third completion tag", cmp_id, 8'h22);
    chk("R9 all retired", pending_cnt, 0);

    // R8 non-normal codes ignored
    issue(8'h66); defer(); reply(8'h66);
    respond(2'b01, 1'b0, 1'b0);
    chk("R8 code 01 no completion", cmp_valid, 0);
    chk("R8 code 01 keeps entry", pending_cnt, 1);
    respond(2'b11, 1'b0, 1'b0);
    chk("R8 code 11 no completion", cmp_valid, 0);
    respond(2'b00, 1'b0, 1'b0);
    chk("R8 normal after others", cmp_valid, 1);
    chk("R8 tag kept", cmp_id, 8'h66);

    // R3 overflow
    for (int k = 0; k < 8; k++) begin
      issue(8'h40 + 8'(k));
      defer();
    end
    chk("R9 table full", pending_cnt, 8);
    issue(8'h99);
    defer();
    chk("R3 overflow flag", err_ovf, 1);
    chk("R3 overflow not stored", pending_cnt, 8);
    reply(8'h99);
    chk("R4 dropped tag unmatched", err_unmatched, 1);
    do_reset();
    chk("R1 reset clears entries", pending_cnt, 0);

    // R2 queue back-pressure
    issue(8'h01); issue(8'h02); issue(8'h03);
    chk("R2 ready low at capacity", iss_ready, 0);
    issue(8'h04);
    defer(); defer(); defer(); defer();
    chk("R2 extra request dropped", pending_cnt, 3);
    chk("R2 ready back", iss_ready, 1);
    do_reset();

    // R10 response beats a defer notice in the same clock
    issue(8'hA1); defer(); reply(8'hA1);
    issue(8'hB2);
    bus_rsp_valid = 1'b1; bus_rsp_code = 2'b00;
    tick();
    bus_rsp_valid = 1'b0; dfr_valid = 1'b1;
    tick();
    dfr_valid = 1'b0;
    chk("R10 response completed", cmp_id, 8'hA1);
    chk("R10 defer ignored", pending_cnt, 0);
    defer();
    chk("R10 request still queued", pending_cnt, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule